// File: doc/BRIEF.md
# Stall-Detection Repair Trigger

This block sits beside an evolutionary search engine and decides the generation at which evolution stops and gate-level repair starts. Each generation ends with one strobe that carries the best fitness of that generation. The block compares this fitness against an absolute quality bar. It also tracks how many generations in a row have reported the same best fitness, which shows that progress has stalled.

Repair is requested by a single-cycle pulse, for whichever of two causes comes first. The first cause is a fitness at or above the bar. The second is a stall run that has grown to a configured limit. The bar is derived once, at configuration time, as a fixed percentage of the maximum achievable fitness. After the pulse the block holds a terminated state until it is reset or restarted.

Top module: `stall_repair_trigger`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `stall_count` is 0, `busy` is 1, `done` is 0 and `repair_fire` is 0.
- R2: A `cfg_load` pulse sets the quality bar to floor(`cfg_max_fit` × PCT / 100), with PCT = 95 by default, and the new bar applies from the next cycle. A strobe whose fitness is greater than or equal to the bar raises `repair_fire` on the next cycle, whatever the stall count is. Such a strobe leaves `stall_count` unchanged.
- R3: The first strobe after reset or restart only records its fitness as the previous best. `stall_count` stays 0 and the strobe never causes a stall-based trigger, even when `stall_limit` is 0.
- R4: A strobe below the bar whose fitness equals the previous best adds one to `stall_count`.
- R5: A strobe below the bar whose fitness differs from the previous best sets `stall_count` to 0 and becomes the new previous best.
- R6: After R4 or R5 has been applied, if the updated `stall_count` is greater than or equal to `stall_limit`, `repair_fire` is high on the next cycle.
- R7: `repair_fire` is high for exactly one cycle. From that cycle onward `busy` is 0 and `done` is 1. Strobes in this state change neither `stall_count` nor `repair_fire`, even when their fitness is above the bar.
- R8: `stall_count` saturates at 2^CNT_W − 1 and never wraps. `stall_limit` is CNT_W+1 bits wide, so a limit above that maximum disables the stall trigger.
- R9: A `restart` pulse returns the block to `busy`, clears `stall_count` and the previous-best record, and keeps the configured bar. A strobe in the same cycle as `restart` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Begins a new run, keeps the configuration |
| cfg_load | input | 1 | Loads the quality bar from `cfg_max_fit` |
| cfg_max_fit | input | FIT_W | Maximum achievable fitness |
| stall_limit | input | CNT_W+1 | Stall run length that triggers repair |
| gen_valid | input | 1 | End-of-generation strobe |
| gen_fitness | input | FIT_W | Best fitness of the generation |
| repair_fire | output | 1 | One-cycle repair request |
| stall_count | output | CNT_W | Consecutive generations with unchanged best fitness |
| busy | output | 1 | Evolution is still running |
| done | output | 1 | Repair has been requested and the run is over |

## Verification
The bench builds the block with FIT_W = 8, CNT_W = 4 and PCT = 95. With these values the stall counter saturates after only fifteen unchanged generations, so saturation is reached in a few dozen cycles. A five-bit limit of 16 then shows that saturation does not wrap and does not fire. With 8-bit fitness, the bars floor(200·0.95) = 190 and floor(255·0.95) = 242 are small enough that strobes can be placed exactly one below and exactly on each bar. A zero stall limit is used to expose the special handling of the first generation.

// File: rtl/stall_trig_pkg.sv
package stall_trig_pkg;

    typedef enum logic [0:0] {
        RUN_EVOLVE = 1'b0,
        RUN_ENDED  = 1'b1
    } run_state_e;

    // Decision taken for one accepted generation strobe
    typedef struct packed {
        logic accept;   // strobe is live (running, not restarting)
        logic above;    // fitness meets the quality bar
        logic step;     // strobe updates the stall tracker
        logic fire;     // repair is requested
    } gen_decision_t;

    localparam int PCT_DEN = 100;

endpackage

// File: rtl/quality_bar.sv
module quality_bar #(
    parameter int FIT_W = 16,
    parameter int PCT   = 95
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [FIT_W-1:0] max_fit,
    output logic [FIT_W-1:0] bar
);
    import stall_trig_pkg::*;

    localparam int PROD_W = FIT_W + 8;

    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] scaled;

    always_comb begin
        product = PROD_W'(max_fit) * PROD_W'(PCT);
        scaled  = product / PROD_W'(PCT_DEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bar <= '1;
        end else if (load) begin
            bar <= scaled[FIT_W-1:0];
        end
    end
endmodule

// File: rtl/stall_tracker.sv
module stall_tracker #(
    parameter int FIT_W = 16,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [FIT_W-1:0] fitness,
    output logic             have_prev,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_next
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [FIT_W-1:0] prev_best;

    always_comb begin
        if (fitness != prev_best) begin
            count_next = '0;
        end else if (count == CNT_MAX) begin
            count_next = count;
        end else begin
            count_next = count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_best <= '0;
            have_prev <= 1'b0;
            count     <= '0;
        end else if (step) begin
            prev_best <= fitness;
            have_prev <= 1'b1;
            if (have_prev) begin
                count <= count_next;
            end
        end
    end
endmodule

// File: rtl/trigger_ctrl.sv
module trigger_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic fire_req,
    output logic fire,
    output logic running
);
    import stall_trig_pkg::*;

    run_state_e state;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state <= RUN_EVOLVE;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (state == RUN_EVOLVE && fire_req) begin
                state <= RUN_ENDED;
                fire  <= 1'b1;
            end
        end
    end

    assign running = (state == RUN_EVOLVE);
endmodule

// File: rtl/stall_repair_trigger.sv
module stall_repair_trigger #(
    parameter int FIT_W = 16,
    parameter int CNT_W = 9,
    parameter int PCT   = 95,
    localparam int LIM_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             cfg_load,
    input  logic [FIT_W-1:0] cfg_max_fit,
    input  logic [LIM_W-1:0] stall_limit,
    input  logic             gen_valid,
    input  logic [FIT_W-1:0] gen_fitness,
    output logic             repair_fire,
    output logic [CNT_W-1:0] stall_count,
    output logic             busy,
    output logic             done
);
    import stall_trig_pkg::*;

    logic [FIT_W-1:0] bar;
    logic             have_prev;
    logic [CNT_W-1:0] cnt_next;
    logic             running;
    gen_decision_t    dec;

    quality_bar #(.FIT_W(FIT_W), .PCT(PCT)) u_bar (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_load),
        .max_fit (cfg_max_fit),
        .bar     (bar)
    );

    always_comb begin
        dec.accept = gen_valid && running && !restart;
        dec.above  = (gen_fitness >= bar);
        dec.step   = dec.accept && !dec.above;
        dec.fire   = dec.accept &&
                     (dec.above ||
                      (have_prev && ({1'b0, cnt_next} >= stall_limit)));
    end

    stall_tracker #(.FIT_W(FIT_W), .CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .clear      (restart),
        .step       (dec.step),
        .fitness    (gen_fitness),
        .have_prev  (have_prev),
        .count      (stall_count),
        .count_next (cnt_next)
    );

    trigger_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .fire_req (dec.fire),
        .fire     (repair_fire),
        .running  (running)
    );

    assign busy = running;
    assign done = !running;
endmodule

// File: rtl/stall_repair_trigger_chk.sv
module stall_repair_trigger_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             restart,
    input logic             repair_fire,
    input logic [CNT_W-1:0] stall_count,
    input logic             busy,
    input logic             done
);
    // R7: the request lasts a single cycle
    assert_fire_single_R7: assert property (@(posedge clk) disable iff (rst)
        repair_fire && !restart |=> !repair_fire);

    // R7: the request coincides with the terminated status
    assert_fire_ends_run_R7: assert property (@(posedge clk) disable iff (rst)
        repair_fire |-> (done && !busy));

    // R7: strobes after termination leave the count alone
    assert_ended_count_stable_R7: assert property (@(posedge clk) disable iff (rst)
        done && !restart |=> $stable(stall_count));

    // R8: the count either clears or does not go down (no wrap)
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        !restart |=> (stall_count == '0) || (stall_count >= $past(stall_count)));

    // R9: restart brings the block back to running with a clear count
    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (rst)
        restart |=> (busy && stall_count == '0 && !repair_fire));
endmodule

bind stall_repair_trigger stall_repair_trigger_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .restart     (restart),
    .repair_fire (repair_fire),
    .stall_count (stall_count),
    .busy        (busy),
    .done        (done)
);

// File: tb/stall_repair_trigger_bench.sv
module stall_repair_trigger_bench;
    localparam int FIT_W = 8;
    localparam int CNT_W = 4;
    localparam int LIM_W = CNT_W + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             restart = 1'b0;
    logic             cfg_load = 1'b0;
    logic [FIT_W-1:0] cfg_max_fit = '0;
    logic [LIM_W-1:0] stall_limit = '0;
    logic             gen_valid = 1'b0;
    logic [FIT_W-1:0] gen_fitness = '0;
    logic             repair_fire;
    logic [CNT_W-1:0] stall_count;
    logic             busy;
    logic             done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    stall_repair_trigger #(.FIT_W(FIT_W), .CNT_W(CNT_W), .PCT(95)) u_stall_repair_trigger (
        .clk (clk), .rst (rst), .restart (restart), .cfg_load (cfg_load),
        .cfg_max_fit (cfg_max_fit), .stall_limit (stall_limit),
        .gen_valid (gen_valid), .gen_fitness (gen_fitness),
        .repair_fire (repair_fire), .stall_count (stall_count),
        .busy (busy), .done (done)
    );

    // vector: {fitness[7:0], expected fire, expected count[3:0]}, limit 3, bar 190
    localparam int NV = 9;
    localparam logic [12:0] VEC [NV] = '{
        {8'd50,  1'b0, 4'd0},   // R3 first strobe only records
        {8'd50,  1'b0, 4'd1},   // R4
        {8'd50,  1'b0, 4'd2},   // R4
        {8'd60,  1'b0, 4'd0},   // R5
        {8'd60,  1'b0, 4'd1},   // R4
        {8'd60,  1'b0, 4'd2},   // R4
        {8'd60,  1'b1, 4'd3},   // R6 count reaches limit
        {8'd60,  1'b0, 4'd3},   // R7 ignored after end
        {8'd190, 1'b0, 4'd3}    // R7 ignored even above bar
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [FIT_W-1:0] f);
        @(negedge clk);
        gen_valid   = 1'b1;
        gen_fitness = f;
        @(posedge clk);
        #1;
        gen_valid = 1'b0;
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        restart = 1'b1;
        @(posedge clk);
        #1;
        restart = 1'b0;
    endtask

    task automatic configure(input logic [FIT_W-1:0] m);
        @(negedge clk);
        cfg_load    = 1'b1;
        cfg_max_fit = m;
        @(posedge clk);
        #1;
        cfg_load = 1'b0;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 count in reset", int'(stall_count), 0);
        check("R1 busy in reset", int'(busy), 1);
        check("R1 fire in reset", int'(repair_fire), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 done after reset", int'(done), 0);

        configure(8'd200);   // R2 bar = 190
        stall_limit = 5'd3;

        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i][12:5]);
            check($sformatf("R6/R7 vec %0d fire", i), int'(repair_fire), int'(VEC[i][4]));
            check($sformatf("R4/R5 vec %0d count", i), int'(stall_count), int'(VEC[i][3:0]));
        end
        check("R7 done after fire", int'(done), 1);
        check("R7 busy after fire", int'(busy), 0);

        // R9 restart, R2 bar boundaries
        pulse_restart();
        check("R9 busy after restart", int'(busy), 1);
        check("R9 count after restart", int'(stall_count), 0);
        strobe(8'd189);
        check("R2 just below bar", int'(repair_fire), 0);
        strobe(8'd190);
        check("R2 at bar fires", int'(repair_fire), 1);
        check("R2 count unchanged", int'(stall_count), 0);
        @(posedge clk);
        #1;
        check("R7 pulse one cycle", int'(repair_fire), 0);

        // R3 zero limit: first strobe must not fire
        stall_limit = 5'd0;
        pulse_restart();
        strobe(8'd5);
        check("R3 first strobe no fire", int'(repair_fire), 0);
        check("R3 first strobe count", int'(stall_count), 0);
        strobe(8'd7);
        check("R6 zero limit fires", int'(repair_fire), 1);

        // R8 saturation with unreachable limit
        stall_limit = 5'd16;
        pulse_restart();
        strobe(8'd1);
        for (int k = 0; k < 20; k++) strobe(8'd1);
        check("R8 count saturates", int'(stall_count), 15);
        check("R8 no fire past max", int'(done), 0);
        strobe(8'd2);
        check("R5 clear after saturation", int'(stall_count), 0);

        // R9 restart drops same-cycle strobe; R2 new bar 242
        configure(8'd255);
        @(negedge clk);
        restart = 1'b1;
        gen_valid = 1'b1;
        gen_fitness = 8'd250;
        @(posedge clk);
        #1;
        restart = 1'b0;
        gen_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R9 strobe with restart dropped", int'(repair_fire), 0);
        strobe(8'd241);
        check("R2 below new bar", int'(repair_fire), 0);
        strobe(8'd242);
        check("R2 at new bar fires", int'(repair_fire), 1);

        // R1 reset mid-run
        pulse_restart();
        strobe(8'd9);
        strobe(8'd9);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1 count cleared by reset", int'(stall_count), 0);
        check("R1 busy after reset", int'(busy), 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule